// File: doc/BRIEF.md
# Coprocessor Compare Flag Generator

This block turns a compare between two coprocessor register values into a 32-bit condition word that the host core can load straight into its flags. Each source register is 64 bits wide. A narrow integer sits in its lower half and a single-precision float sits in its upper half. A 3-bit minor opcode and a bank select together choose one of three comparisons:

- a 32-bit signed-integer compare;
- a 64-bit signed-integer compare;
- a single-precision float compare.

The integer compares subtract B from A and report negative, zero, carry and overflow in the usual subtract sense. The float compare is ordered: it reports less-than in N, equal in Z and greater-than in C, and always clears V. It accepts finite values only; NaN and infinity inputs are outside its range.

The compare logic is combinational. Its result is captured in one output register, so the status word and the illegal-opcode flag appear one clock after the inputs are presented. Any minor opcode other than the two compare codes raises the illegal flag and yields an all-zero status word.

Top module: `copro_cmp_flags`

## Requirements
- R1: The status word carries N at bit 31, Z at bit 30, C at bit 29 and V at bit 28. Bits 27 to 0 are always zero.
- R2: With minor opcode 4 and `int_bank` = 1, the unit compares bits 31:0 of both sources as signed integers. Bits 63:32 have no effect on the result.
- R3: For both integer compares, Z is 1 exactly when A equals B. N is the sign bit of A minus B, wrapped to the operand width.
- R4: For both integer compares, C is 1 exactly when A is greater than or equal to B taken as unsigned numbers, that is, when the subtraction produces no borrow.
- R5: For both integer compares, V is 1 exactly when the true signed difference A minus B does not fit in the operand width.
- R6: Minor opcode 5 compares all 64 bits of both sources as signed integers, whatever the value of `int_bank`.
- R7: With minor opcode 4 and `int_bank` = 0, the unit compares bits 63:32 of both sources as IEEE single-precision floats, with the sign in bit 63. It sets N when A < B, Z when A = B and C when A > B, so exactly one of the three is set, and V is always 0. Bits 31:0 have no effect on the result.
- R8: In the float compare, +0 (0x00000000) and -0 (0x80000000) are equal, giving Z = 1 and N = C = 0.
- R9: Any minor opcode other than 4 or 5 sets `illegal_op` to 1 and makes the status word all zeros. Opcodes 4 and 5 leave `illegal_op` at 0.
- R10: Outputs are registered and appear one clock after the inputs are presented. A synchronous active-high `rst` clears both the status word and `illegal_op` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_minor | input | 3 | Minor opcode: 4 selects the narrow compare, 5 selects the 64-bit integer compare |
| int_bank | input | 1 | With opcode 4: 1 selects the 32-bit integer compare, 0 selects the float compare |
| src_a | input | 64 | First operand register value (A) |
| src_b | input | 64 | Second operand register value (B) |
| status | output | 32 | Condition word: N, Z, C and V in bits 31 to 28, zeros below |
| illegal_op | output | 1 | Set when the minor opcode is not a compare code |

## Verification
The bench builds the block with its default half-register width of 32. At that width the operands are exactly 32 and 64 bits, which brings the sign-boundary cases within reach of directed vectors: the most negative value minus one, wrap-around overflow, and unsigned-versus-signed ordering. A behavioural model predicts every cycle's output. It takes the integer flags from wide signed arithmetic, and it converts float bit patterns to real numbers by their exponent and fraction before comparing them. Directed cases cover both zeros, denormals, equal negatives, garbage in the unused register halves and every illegal opcode. A long run of random operands and opcodes follows.

// File: rtl/copro_cmp_flags_pkg.sv
package copro_cmp_flags_pkg;

    // Width of one register half; a full register is two halves.
    localparam int HALF_W = 32;
    localparam int REG_W  = 2 * HALF_W;
    localparam int OP_W   = 3;
    localparam int STAT_W = 32;

    // Flag bit positions in the status word; the host decodes these.
    localparam int POS_N = STAT_W - 1;
    localparam int POS_Z = STAT_W - 2;
    localparam int POS_C = STAT_W - 3;
    localparam int POS_V = STAT_W - 4;

    // Minor opcodes that select a compare.
    localparam logic [OP_W-1:0] OP_CMP_NARROW = OP_W'(4);
    localparam logic [OP_W-1:0] OP_CMP_WIDE   = OP_W'(5);

    typedef enum logic [1:0] {
        CM_INT_NARROW = 2'd0,
        CM_INT_WIDE   = 2'd1,
        CM_FLT_SINGLE = 2'd2,
        CM_NONE       = 2'd3
    } cmp_mode_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } cmp_flags_t;

    localparam cmp_flags_t FLAGS_CLEAR = '{n: 1'b0, z: 1'b0, c: 1'b0, v: 1'b0};

    function automatic cmp_mode_e decode_mode(input logic [OP_W-1:0] op,
                                              input logic int_sel);
        cmp_mode_e m;
        if (op == OP_CMP_NARROW)
            m = int_sel ? CM_INT_NARROW : CM_FLT_SINGLE;
        else if (op == OP_CMP_WIDE)
            m = CM_INT_WIDE;
        else
            m = CM_NONE;
        return m;
    endfunction

    function automatic logic [STAT_W-1:0] pack_flags(input cmp_flags_t f);
        logic [STAT_W-1:0] w;
        w        = '0;
        w[POS_N] = f.n;
        w[POS_Z] = f.z;
        w[POS_C] = f.c;
        w[POS_V] = f.v;
        return w;
    endfunction

endpackage

// File: rtl/copro_int_sub_cmp.sv
// Subtract-based signed integer compare of configurable width.
module copro_int_sub_cmp
    import copro_cmp_flags_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output cmp_flags_t   flags
);
    localparam int MSB = W - 1;

    logic [W-1:0] diff;
    logic         sa, sb, sr;

    always_comb begin
        diff = op_a - op_b;
        sa   = op_a[MSB];
        sb   = op_b[MSB];
        sr   = diff[MSB];

        flags.n = sr;
        flags.z = (diff == '0);
        // No borrow: built from the three operand sign bits.
        flags.c = (sa & ~sb) | (sa & ~sr) | (~sb & ~sr);
        // Signed overflow: operand signs differ and result sign follows B.
        flags.v = (sa & ~sb & ~sr) | (~sa & sb & sr);
    end

endmodule

// File: rtl/copro_flt_cmp.sv
// Ordered compare of two finite sign-magnitude floating-point words.
module copro_flt_cmp
    import copro_cmp_flags_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output cmp_flags_t   flags
);
    localparam int MAG_W = W - 1;

    logic             sa, sb;
    logic [MAG_W-1:0] ma, mb;
    logic             both_zero, mag_lt, mag_gt, eq, lt;

    always_comb begin
        sa = op_a[W-1];
        sb = op_b[W-1];
        ma = op_a[MAG_W-1:0];
        mb = op_b[MAG_W-1:0];

        both_zero = (ma == '0) && (mb == '0);
        mag_lt    = (ma < mb);
        mag_gt    = (ma > mb);

        eq = both_zero || (op_a == op_b);

        if (eq)
            lt = 1'b0;
        else if (sa != sb)
            lt = sa;            // negative side is the smaller one
        else if (sa)
            lt = mag_gt;        // both negative: larger magnitude is smaller
        else
            lt = mag_lt;        // both positive

        flags.n = lt;
        flags.z = eq;
        flags.c = ~eq & ~lt;
        flags.v = 1'b0;
    end

endmodule

// File: rtl/copro_stat_reg.sv
// Output stage: holds the status word and the illegal flag for one cycle.
module copro_stat_reg
    import copro_cmp_flags_pkg::*;
#(
    parameter int SW = STAT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] d_status,
    input  logic          d_illegal,
    output logic [SW-1:0] q_status,
    output logic          q_illegal
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_status  <= '0;
            q_illegal <= 1'b0;
        end else begin
            q_status  <= d_status;
            q_illegal <= d_illegal;
        end
    end

endmodule

// File: rtl/copro_cmp_flags.sv
module copro_cmp_flags
    import copro_cmp_flags_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W-1:0]   op_minor,
    input  logic              int_bank,
    input  logic [REG_W-1:0]  src_a,
    input  logic [REG_W-1:0]  src_b,
    output logic [STAT_W-1:0] status,
    output logic              illegal_op
);
    localparam int N_INT = 2;   // narrow and wide integer compares

    cmp_mode_e  mode;
    cmp_flags_t int_flags [N_INT];
    cmp_flags_t flt_flags;
    cmp_flags_t sel_flags;
    logic [STAT_W-1:0] next_status;
    logic              next_illegal;

    // One subtract compare per integer width: index 0 narrow, 1 wide.
    for (genvar g = 0; g < N_INT; g++) begin : g_int
        localparam int GW = (g == 0) ? HALF_W : REG_W;
        copro_int_sub_cmp #(.W(GW)) u_int (
            .op_a  (src_a[GW-1:0]),
            .op_b  (src_b[GW-1:0]),
            .flags (int_flags[g])
        );
    end

    copro_flt_cmp #(.W(HALF_W)) u_flt (
        .op_a  (src_a[REG_W-1:HALF_W]),
        .op_b  (src_b[REG_W-1:HALF_W]),
        .flags (flt_flags)
    );

    always_comb begin
        mode = decode_mode(op_minor, int_bank);
        unique case (mode)
            CM_INT_NARROW: sel_flags = int_flags[0];
            CM_INT_WIDE:   sel_flags = int_flags[1];
            CM_FLT_SINGLE: sel_flags = flt_flags;
            default:       sel_flags = FLAGS_CLEAR;
        endcase
        next_illegal = (mode == CM_NONE);
        next_status  = pack_flags(sel_flags);
    end

    copro_stat_reg #(.SW(STAT_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .d_status  (next_status),
        .d_illegal (next_illegal),
        .q_status  (status),
        .q_illegal (illegal_op)
    );

endmodule

// File: rtl/copro_cmp_flags_chk.sv
module copro_cmp_flags_chk
    import copro_cmp_flags_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [OP_W-1:0]   op_minor,
    input logic              int_bank,
    input logic [REG_W-1:0]  src_a,
    input logic [REG_W-1:0]  src_b,
    input logic [STAT_W-1:0] status,
    input logic              illegal_op
);

    AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
        status[POS_V-1:0] == '0);  // R1

    AST_ILLEGAL_CLEARS: assert property (@(posedge clk) disable iff (rst)
        illegal_op |-> (status == '0));  // R9

    AST_ILLEGAL_DECODE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_minor != OP_CMP_NARROW && op_minor != OP_CMP_WIDE))
        |-> illegal_op);  // R9

    AST_LEGAL_NOT_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_minor == OP_CMP_NARROW || op_minor == OP_CMP_WIDE))
        |-> !illegal_op);  // R9

    AST_FLT_V_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_minor == OP_CMP_NARROW && !int_bank))
        |-> !status[POS_V]);  // R7

    AST_FLT_ONE_RELATION: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_minor == OP_CMP_NARROW && !int_bank))
        |-> ($countones(status[POS_N:POS_C]) == 1));  // R7

    AST_NARROW_EQ_Z: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_minor == OP_CMP_NARROW && int_bank
                              && src_a[HALF_W-1:0] == src_b[HALF_W-1:0]))
        |-> (status[POS_Z] && status[POS_C] && !status[POS_N] && !status[POS_V]));  // R3

    AST_WIDE_EQ_Z: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(op_minor == OP_CMP_WIDE && src_a == src_b))
        |-> (status[POS_Z] && status[POS_C]));  // R6

    AST_RESET_CLEARS: assert property (@(posedge clk)
        $past(rst) |-> (status == '0 && !illegal_op));  // R10

endmodule

bind copro_cmp_flags copro_cmp_flags_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .op_minor   (op_minor),
    .int_bank   (int_bank),
    .src_a      (src_a),
    .src_b      (src_b),
    .status     (status),
    .illegal_op (illegal_op)
);

// File: tb/copro_cmp_flags_test.sv
module copro_cmp_flags_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  op_minor = 3'd0;
    logic        int_bank = 1'b0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic [31:0] status;
    logic        illegal_op;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    copro_cmp_flags uut (
        .clk(clk), .rst(rst), .op_minor(op_minor), .int_bank(int_bank),
        .src_a(src_a), .src_b(src_b), .status(status), .illegal_op(illegal_op)
    );

    // Float bit pattern to real, finite values only.
    function automatic real f2r(input logic [31:0] bits);
        int  e;
        real m, v;
        e = int'(bits[30:23]);
        m = real'(bits[22:0]);
        if (e == 0) v = m * (2.0 ** (-149));
        else        v = (1.0 + m / 8388608.0) * (2.0 ** (e - 127));
        return bits[31] ? -v : v;
    endfunction

    // Expected {illegal, status} from the requirements.
    function automatic logic [32:0] model(input logic [2:0] op, input logic bank,
                                          input logic [63:0] a, input logic [63:0] b);
        logic n, z, c, v;
        logic signed [64:0] wa, wb, wd;
        real ra, rb;
        n = 0; z = 0; c = 0; v = 0;
        if (op == 3'd4 && !bank) begin            // R7 float
            ra = f2r(a[63:32]);
            rb = f2r(b[63:32]);
            n = (ra < rb); z = (ra == rb); c = (ra > rb); v = 0;
        end else if (op == 3'd4 || op == 3'd5) begin
            if (op == 3'd4) begin                  // R2 narrow
                wa = 65'(signed'(a[31:0]));
                wb = 65'(signed'(b[31:0]));
                wd = wa - wb;
                n = wd[31];                        // R3 wrapped sign
                z = (a[31:0] == b[31:0]);
                c = (a[31:0] >= b[31:0]);          // R4
                v = (wd > 65'sd2147483647) || (wd < -65'sd2147483648); // R5
            end else begin                         // R6 wide
                wa = signed'({a[63], a});
                wb = signed'({b[63], b});
                wd = wa - wb;
                n = wd[63];
                z = (a == b);
                c = (a >= b);
                v = (wd[64] != wd[63]);
            end
        end else begin
            return {1'b1, 32'h0};                  // R9
        end
        return {1'b0, n, z, c, v, 28'h0};          // R1
    endfunction

    task automatic check(input string tag, input logic [32:0] exp);
        checks++;
        if ({illegal_op, status} !== exp) begin
            errors++;
            $display("FAIL %s: got illegal=%0b status=%08h, expected illegal=%0b status=%08h",
                     tag, illegal_op, status, exp[32], exp[31:0]);
        end
    endtask

    // Drive at a falling edge, compare one clock later (one register stage).
    task automatic apply(input string tag, input logic [2:0] op, input logic bank,
                         input logic [63:0] a, input logic [63:0] b);
        logic [32:0] exp;
        op_minor = op; int_bank = bank; src_a = a; src_b = b;
        exp = model(op, bank, a, b);
        @(negedge clk);
        check(tag, exp);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset state", 33'h0);
        rst = 1'b0;

        // Narrow integer compare, upper halves differ to show they are ignored.
        apply("R2 R3 equal lower", 3'd4, 1'b1, 64'hDEAD0000_00001234, 64'h12340000_00001234);
        apply("R3 R4 less signed", 3'd4, 1'b1, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001);
        apply("R4 unsigned below", 3'd4, 1'b1, 64'h1, 64'h2);
        apply("R5 min minus one",  3'd4, 1'b1, 64'h8000_0000, 64'h1);
        apply("R5 max minus neg",  3'd4, 1'b1, 64'h7FFF_FFFF, 64'hFFFF_FFFF);
        apply("R2 upper ignored",  3'd4, 1'b1, 64'hFFFFFFFF_00000005, 64'h00000000_00000005);

        // Wide integer compare in both banks.
        apply("R6 wide equal",     3'd5, 1'b1, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0);
        apply("R6 upper decides",  3'd5, 1'b0, 64'h0000_0001_0000_0000, 64'h0000_0000_FFFF_FFFF);
        apply("R5 R6 wide ovf",    3'd5, 1'b1, 64'h8000_0000_0000_0000, 64'h1);
        apply("R4 R6 wide borrow", 3'd5, 1'b0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF);

        // Float compare on upper halves; lower halves hold noise.
        apply("R7 one lt two",     3'd4, 1'b0, {32'h3F80_0000, 32'h0}, {32'h4000_0000, 32'hFFFF});
        apply("R7 two gt one",     3'd4, 1'b0, {32'h4000_0000, 32'h5}, {32'h3F80_0000, 32'h9});
        apply("R7 neg lt pos",     3'd4, 1'b0, {32'hBF80_0000, 32'h0}, {32'h3F80_0000, 32'h0});
        apply("R7 neg magnitudes", 3'd4, 1'b0, {32'hC000_0000, 32'h0}, {32'hBF80_0000, 32'h0});
        apply("R7 equal negs",     3'd4, 1'b0, {32'hC000_0000, 32'h1}, {32'hC000_0000, 32'h2});
        apply("R7 denormal gt 0",  3'd4, 1'b0, {32'h0000_0001, 32'h0}, {32'h0000_0000, 32'h0});
        apply("R8 plus minus 0",   3'd4, 1'b0, {32'h0000_0000, 32'h0}, {32'h8000_0000, 32'h0});
        apply("R8 minus plus 0",   3'd4, 1'b0, {32'h8000_0000, 32'h7}, {32'h0000_0000, 32'h3});

        // Every non-compare opcode.
        for (int op = 0; op < 8; op++) begin
            if (op != 4 && op != 5)
                apply("R9 illegal opcode", 3'(op), op[0], 64'h5555_AAAA_1234_0001, 64'h0);
        end

        // Reset after an illegal result.
        apply("R9 before reset", 3'd7, 1'b1, 64'h1, 64'h2);
        rst = 1'b1;
        op_minor = 3'd4; int_bank = 1'b1; src_a = 64'h1; src_b = 64'h2;
        @(negedge clk);
        check("R10 reset clears", 33'h0);
        rst = 1'b0;

        // Random mix; float exponents kept finite.
        for (int i = 0; i < 3000; i++) begin
            logic [63:0] a, b;
            logic [2:0]  op;
            a  = {$urandom, $urandom};
            b  = ($urandom_range(0, 3) == 0) ? a : {$urandom, $urandom};
            op = ($urandom_range(0, 7) == 0) ? 3'($urandom) : 3'($urandom_range(4, 5));
            if (a[62:55] == 8'hFF) a[62] = 1'b0;
            if (b[62:55] == 8'hFF) b[62] = 1'b0;
            apply("R1 R3 R4 R5 R7 random", op, 1'($urandom), a, b);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule